// File: doc/BRIEF.md
# Memory-Ordering Constraint Checker

This block sits beside a load/store queue and answers one question for a pair of memory operations. The older operation is `a` and the younger is `b`, both taken in program order and both aimed at main memory. The question is whether the weak-memory ordering rules forbid `b` from being performed ahead of `a`. Each query describes both operations: kind, byte address, access size and annotation bits. It also carries pair-level flags: pairing, an intervening fence, address, data and control dependencies, and what the queue observed about the values the loads obtained. Observed values cover a load-to-load writer mismatch, `b` reading what `a` wrote, and dependency chains through an intermediate operation `m`.

The block evaluates all thirteen preserved-order conditions in parallel. It returns a `must_order` bit and a 13-bit reason vector with one bit per condition. Queries enter on a valid/ready handshake and the result leaves one cycle later on a second valid/ready pair. A query is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A result presented with `out_ready` low stays unchanged until it is taken.

Top module: `mo_order_checker`

## Requirements
- R1: Kind codes are 0 load, 1 store, 2 AMO, 3 store-conditional. Size codes 0..3 mean 1, 2, 4 or 8 bytes starting at the address, and a span that runs past the top address does not wrap to address 0. reason[0] is set when `b` is store-like (kind 1, 2 or 3) and any byte of `a` coincides with a byte of `b`.
- R2: reason[1] is set when both operations are load-like (kind 0 or 2), their spans share a byte, `st_between` is low and `rd_diff_src` is high.
- R3: reason[2] is set when `a` is kind 2 or 3, `b` is load-like and `b_from_a` is high.
- R4: reason[3] follows `fence_ab` for every combination of kinds.
- R5: reason[4] is set when `a_acq` is high and `a` is load-like, and reason[5] is set when `b_rel` is high and `b` is store-like. An acquire bit on a kind-1 or kind-3 `a` has no effect, and neither does a release bit on a kind-0 `b`.
- R6: reason[6] is set when both operations carry an effective (kind-qualified as in R5) acquire or release together with their RCsc bit. reason[7] follows `pair_ab`.
- R7: reason[8] follows `dep_addr_ab`, and reason[9] is set when `dep_data_ab` is high and `b` is store-like.
- R8: reason[10] is set when `dep_ctrl_ab` is high and `b` is store-like. A control dependency into a kind-0 `b` gives no ordering.
- R9: reason[11] is set when `b` is load-like, `m_st_dep` is high and `b_from_m` is high. reason[12] is set when `b` is store-like and `m_addr_dep` is high.
- R10: Bit k-1 of `reason` stands for condition k, and `must_order` is high exactly when some reason bit is high.
- R11: A query accepted at an edge appears on the outputs with `out_valid` high right after that edge. With `out_ready` high and no new query, `out_valid` falls after the next edge.
- R12: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `must_order` and `reason` hold their values.
- R13: During reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Query valid |
| in_ready | output | 1 | Query accepted when high with in_valid |
| a_kind | input | 2 | Kind of older operation |
| a_addr | input | ADDR_W | Byte address of older operation |
| a_size | input | 2 | Log2 byte count of older operation |
| a_acq | input | 1 | Acquire annotation on older operation |
| a_rel | input | 1 | Release annotation on older operation |
| a_rcsc | input | 1 | Older annotation is of the RCsc flavour |
| b_kind | input | 2 | Kind of younger operation |
| b_addr | input | ADDR_W | Byte address of younger operation |
| b_size | input | 2 | Log2 byte count of younger operation |
| b_acq | input | 1 | Acquire annotation on younger operation |
| b_rel | input | 1 | Release annotation on younger operation |
| b_rcsc | input | 1 | Younger annotation is of the RCsc flavour |
| pair_ab | input | 1 | a and b form a paired operation |
| fence_ab | input | 1 | A fence between them orders a before b |
| dep_addr_ab | input | 1 | b address depends on a |
| dep_data_ab | input | 1 | b stored data depends on a |
| dep_ctrl_ab | input | 1 | b is control dependent on a |
| rd_diff_src | input | 1 | Loads got the shared byte from different writers |
| st_between | input | 1 | A store to the shared byte lies between a and b |
| b_from_a | input | 1 | b obtains the value written by a |
| m_st_dep | input | 1 | An intermediate store m has an address or data dependency on a |
| b_from_m | input | 1 | b obtains the value written by that m |
| m_addr_dep | input | 1 | Some intermediate instruction has an address dependency on a |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| must_order | output | 1 | b must not be performed before a |
| reason | output | 13 | Per-condition firing mask |

## Verification
Most bad internal state shows up in the first result after the faulty query, one edge after acceptance. Examples are a wrongly sized span, an overlap that wraps at the top of the address space, and a kind qualifier applied to the wrong side. Each appears as a wrong bit in `reason` and, in most cases, a wrong `must_order`. Handshake faults only appear under back-pressure. A lost or overwritten output register shows as a result that changes while `out_ready` is low, or as `in_ready` staying high at that time, within the stalled cycles. A stuck `out_valid` shows one edge after the consumer drains the result.

// File: rtl/mo_pkg.sv
package mo_pkg;

  typedef enum logic [1:0] {
    MO_LOAD  = 2'd0,
    MO_STORE = 2'd1,
    MO_AMO   = 2'd2,
    MO_SC    = 2'd3
  } mo_kind_e;

  localparam int unsigned NUM_RULES = 13;

  // bit positions of the reason vector (condition k sits at k-1)
  localparam int unsigned RB_ST_OVL   = 0;
  localparam int unsigned RB_LD_LD    = 1;
  localparam int unsigned RB_ATOM_FWD = 2;
  localparam int unsigned RB_FENCE    = 3;
  localparam int unsigned RB_ACQ      = 4;
  localparam int unsigned RB_REL      = 5;
  localparam int unsigned RB_RCSC     = 6;
  localparam int unsigned RB_PAIR     = 7;
  localparam int unsigned RB_DEP_ADDR = 8;
  localparam int unsigned RB_DEP_DATA = 9;
  localparam int unsigned RB_DEP_CTRL = 10;
  localparam int unsigned RB_PIPE_LD  = 11;
  localparam int unsigned RB_PIPE_ST  = 12;

  function automatic logic kind_reads(input logic [1:0] k);
    return (k == MO_LOAD) || (k == MO_AMO);
  endfunction

  function automatic logic kind_writes(input logic [1:0] k);
    return (k != MO_LOAD);
  endfunction

  function automatic logic kind_atomic_wr(input logic [1:0] k);
    return (k == MO_AMO) || (k == MO_SC);
  endfunction

endpackage

// File: rtl/mo_span_overlap.sv
module mo_span_overlap #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [SIZE_W-1:0] a_size,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [SIZE_W-1:0] b_size,
  output logic              hit
);
  // one extra bit so a span near the top never wraps to low addresses
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] a_lo, a_end, b_lo, b_end;

  always_comb begin
    a_lo  = {1'b0, a_addr};
    b_lo  = {1'b0, b_addr};
    a_end = a_lo + (EXT_W'(1) << a_size);
    b_end = b_lo + (EXT_W'(1) << b_size);
    hit   = (a_lo < b_end) && (b_lo < a_end);
  end

endmodule

// File: rtl/mo_rule_eval.sv
module mo_rule_eval
  import mo_pkg::*;
#(
  parameter int unsigned NR = NUM_RULES
) (
  input  logic [1:0]    a_kind,
  input  logic [1:0]    b_kind,
  input  logic          a_acq,
  input  logic          a_rel,
  input  logic          a_rcsc,
  input  logic          b_acq,
  input  logic          b_rel,
  input  logic          b_rcsc,
  input  logic          ovl,
  input  logic          pair_ab,
  input  logic          fence_ab,
  input  logic          dep_addr_ab,
  input  logic          dep_data_ab,
  input  logic          dep_ctrl_ab,
  input  logic          rd_diff_src,
  input  logic          st_between,
  input  logic          b_from_a,
  input  logic          m_st_dep,
  input  logic          b_from_m,
  input  logic          m_addr_dep,
  output logic [NR-1:0] reason,
  output logic          must_order
);
  logic a_rd, a_wr, b_rd, b_wr;
  logic a_acq_eff, a_rel_eff, b_acq_eff, b_rel_eff;
  logic a_sc_ann, b_sc_ann;

  always_comb begin
    a_rd = kind_reads(a_kind);
    a_wr = kind_writes(a_kind);
    b_rd = kind_reads(b_kind);
    b_wr = kind_writes(b_kind);

    // annotations only count on the side of the access they can guard
    a_acq_eff = a_acq & a_rd;
    a_rel_eff = a_rel & a_wr;
    b_acq_eff = b_acq & b_rd;
    b_rel_eff = b_rel & b_wr;
    a_sc_ann  = a_rcsc & (a_acq_eff | a_rel_eff);
    b_sc_ann  = b_rcsc & (b_acq_eff | b_rel_eff);

    reason = '0;
    reason[RB_ST_OVL]   = b_wr & ovl;
    reason[RB_LD_LD]    = a_rd & b_rd & ovl & ~st_between & rd_diff_src;
    reason[RB_ATOM_FWD] = kind_atomic_wr(a_kind) & b_rd & b_from_a;
    reason[RB_FENCE]    = fence_ab;
    reason[RB_ACQ]      = a_acq_eff;
    reason[RB_REL]      = b_rel_eff;
    reason[RB_RCSC]     = a_sc_ann & b_sc_ann;
    reason[RB_PAIR]     = pair_ab;
    reason[RB_DEP_ADDR] = dep_addr_ab;
    reason[RB_DEP_DATA] = dep_data_ab & b_wr;
    reason[RB_DEP_CTRL] = dep_ctrl_ab & b_wr;
    reason[RB_PIPE_LD]  = b_rd & m_st_dep & b_from_m;
    reason[RB_PIPE_ST]  = b_wr & m_addr_dep;

    must_order = |reason;
  end

  // a load-only younger operation can never trip the store-side conditions
  always_comb begin
    if (b_kind == MO_LOAD) begin
      a_r1_load_b_no_overlap_rule: assert (reason[RB_ST_OVL] == 1'b0);
      a_r8_load_b_no_ctrl_rule:    assert (reason[RB_DEP_CTRL] == 1'b0);
    end
  end

endmodule

// File: rtl/mo_pipe_reg.sv
module mo_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r11_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r11_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/mo_order_checker.sv
module mo_order_checker
  import mo_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NR     = NUM_RULES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        a_kind,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [1:0]        a_size,
  input  logic              a_acq,
  input  logic              a_rel,
  input  logic              a_rcsc,
  input  logic [1:0]        b_kind,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [1:0]        b_size,
  input  logic              b_acq,
  input  logic              b_rel,
  input  logic              b_rcsc,
  input  logic              pair_ab,
  input  logic              fence_ab,
  input  logic              dep_addr_ab,
  input  logic              dep_data_ab,
  input  logic              dep_ctrl_ab,
  input  logic              rd_diff_src,
  input  logic              st_between,
  input  logic              b_from_a,
  input  logic              m_st_dep,
  input  logic              b_from_m,
  input  logic              m_addr_dep,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              must_order,
  output logic [NR-1:0]     reason
);
  localparam int unsigned RES_W = NR + 1;

  logic          ovl;
  logic [NR-1:0] reason_c;
  logic          must_c;
  logic [RES_W-1:0] res_q;

  mo_span_overlap #(.ADDR_W(ADDR_W), .SIZE_W(2)) u_ovl (
    .a_addr (a_addr),
    .a_size (a_size),
    .b_addr (b_addr),
    .b_size (b_size),
    .hit    (ovl)
  );

  mo_rule_eval #(.NR(NR)) u_rules (
    .a_kind      (a_kind),
    .b_kind      (b_kind),
    .a_acq       (a_acq),
    .a_rel       (a_rel),
    .a_rcsc      (a_rcsc),
    .b_acq       (b_acq),
    .b_rel       (b_rel),
    .b_rcsc      (b_rcsc),
    .ovl         (ovl),
    .pair_ab     (pair_ab),
    .fence_ab    (fence_ab),
    .dep_addr_ab (dep_addr_ab),
    .dep_data_ab (dep_data_ab),
    .dep_ctrl_ab (dep_ctrl_ab),
    .rd_diff_src (rd_diff_src),
    .st_between  (st_between),
    .b_from_a    (b_from_a),
    .m_st_dep    (m_st_dep),
    .b_from_m    (b_from_m),
    .m_addr_dep  (m_addr_dep),
    .reason      (reason_c),
    .must_order  (must_c)
  );

  mo_pipe_reg #(.W(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({must_c, reason_c}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q)
  );

  assign must_order = res_q[NR];
  assign reason     = res_q[NR-1:0];

  a_r10_must_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (must_order == (reason != '0)));

  a_r5_store_acq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (a_kind == MO_STORE || a_kind == MO_SC)) |=> !reason[RB_ACQ]);

  a_r4_fence_carried: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (reason[RB_FENCE] == $past(fence_ab)));

endmodule

// File: tb/mo_order_checker_tb.sv
`timescale 1ns/1ps
module mo_order_checker_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [1:0]  ak;
    logic [31:0] aa;
    logic [1:0]  asz;
    logic aacq, arel, arcsc;
    logic [1:0]  bk;
    logic [31:0] ba;
    logic [1:0]  bsz;
    logic bacq, brel, brcsc;
    logic pair, fence, daddr, ddata, dctrl, diff, stb, bfa, mst, bfm, madr;
  } d_t;

  d_t cur;
  logic rst_n, in_valid, in_ready, out_valid, out_ready, must_order;
  logic [12:0] reason;
  int checks = 0;
  int errors = 0;

  mo_order_checker u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_kind(cur.ak), .a_addr(cur.aa), .a_size(cur.asz),
    .a_acq(cur.aacq), .a_rel(cur.arel), .a_rcsc(cur.arcsc),
    .b_kind(cur.bk), .b_addr(cur.ba), .b_size(cur.bsz),
    .b_acq(cur.bacq), .b_rel(cur.brel), .b_rcsc(cur.brcsc),
    .pair_ab(cur.pair), .fence_ab(cur.fence), .dep_addr_ab(cur.daddr),
    .dep_data_ab(cur.ddata), .dep_ctrl_ab(cur.dctrl), .rd_diff_src(cur.diff),
    .st_between(cur.stb), .b_from_a(cur.bfa), .m_st_dep(cur.mst),
    .b_from_m(cur.bfm), .m_addr_dep(cur.madr),
    .out_valid(out_valid), .out_ready(out_ready),
    .must_order(must_order), .reason(reason)
  );

  function automatic string req_of(int b);
    case (b)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
      4, 5: return "R5";  6, 7: return "R6";  8, 9: return "R7";
      10: return "R8";  default: return "R9";
    endcase
  endfunction

  function automatic logic [12:0] exp_reason(d_t d);
    logic [12:0] e = '0;
    bit ard = (d.ak == 2'd0) || (d.ak == 2'd2);
    bit awr = (d.ak != 2'd0);
    bit brd = (d.bk == 2'd0) || (d.bk == 2'd2);
    bit bwr = (d.bk != 2'd0);
    bit share = 0;
    bit asc, bsc;
    for (int i = 0; i < (1 << d.asz); i++)
      for (int j = 0; j < (1 << d.bsz); j++)
        if (({1'b0, d.aa} + 33'(i)) == ({1'b0, d.ba} + 33'(j))) share = 1;
    asc = d.arcsc && ((d.aacq && ard) || (d.arel && awr));
    bsc = d.brcsc && ((d.bacq && brd) || (d.brel && bwr));
    e[0]  = bwr && share;
    e[1]  = ard && brd && share && !d.stb && d.diff;
    e[2]  = (d.ak >= 2'd2) && brd && d.bfa;
    e[3]  = d.fence;
    e[4]  = d.aacq && ard;
    e[5]  = d.brel && bwr;
    e[6]  = asc && bsc;
    e[7]  = d.pair;
    e[8]  = d.daddr;
    e[9]  = d.ddata && bwr;
    e[10] = d.dctrl && bwr;
    e[11] = brd && d.mst && d.bfm;
    e[12] = bwr && d.madr;
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_result(d_t d, string tag);
    logic [12:0] e = exp_reason(d);
    check(out_valid === 1'b1, "R11", {tag, " out_valid"}, longint'(out_valid), 1);
    for (int b = 0; b < 13; b++)
      if (reason[b] !== e[b]) begin
        check(0, req_of(b), {tag, " reason"}, longint'(reason), longint'(e));
        return;
      end
    check(1, "R1", tag, 0, 0);
    check(must_order === (e != 0), "R10", {tag, " must_order"},
          longint'(must_order), longint'(e != 0));
  endtask

  function automatic d_t blank();
    d_t d;
    d.ak = 0; d.aa = 0; d.asz = 0; d.aacq = 0; d.arel = 0; d.arcsc = 0;
    d.bk = 0; d.ba = 0; d.bsz = 0; d.bacq = 0; d.brel = 0; d.brcsc = 0;
    d.pair = 0; d.fence = 0; d.daddr = 0; d.ddata = 0; d.dctrl = 0;
    d.diff = 0; d.stb = 0; d.bfa = 0; d.mst = 0; d.bfm = 0; d.madr = 0;
    return d;
  endfunction

  function automatic bit coin();
    return ($urandom % 4) == 0;
  endfunction

  function automatic d_t rand_d();
    d_t d;
    logic [31:0] base = $urandom & 32'hFFFF_FFF0;
    d.ak = 2'($urandom); d.bk = 2'($urandom);
    d.asz = 2'($urandom); d.bsz = 2'($urandom);
    d.aa = base | ($urandom % 16);
    d.ba = (($urandom % 4) != 0) ? (base | ($urandom % 16)) : $urandom;
    d.aacq = coin(); d.arel = coin(); d.arcsc = $urandom % 2;
    d.bacq = coin(); d.brel = coin(); d.brcsc = $urandom % 2;
    d.pair = coin(); d.fence = coin(); d.daddr = coin(); d.ddata = coin();
    d.dctrl = coin(); d.diff = $urandom % 2; d.stb = $urandom % 2;
    d.bfa = $urandom % 2; d.mst = coin(); d.bfm = $urandom % 2; d.madr = coin();
    return d;
  endfunction

  task automatic send(d_t d, string tag);
    @(negedge clk);
    cur = d; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(d, tag);
  endtask

  initial begin
    #(4.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    d_t d, d2;
    void'($urandom(32'h0A51_3C7D));
    cur = blank(); in_valid = 0; out_ready = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R13", "out_valid in reset", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R13", "in_ready in reset", longint'(in_ready), 1);
    rst_n = 1;

    // R1 store b overlapping by one byte; adjacent spans do not touch
    d = blank(); d.ak = 0; d.aa = 32'h100; d.asz = 2; d.bk = 1; d.ba = 32'h103;
    send(d, "R1 overlap last byte");
    d.ba = 32'h104; send(d, "R1 adjacent no overlap");
    // R1 top of address space must not wrap onto address 0
    d.aa = 32'hFFFF_FFFC; d.asz = 3; d.ba = 32'h0; d.bsz = 3;
    send(d, "R1 no wrap");
    // R2 load-load with and without an intervening store
    d = blank(); d.aa = 32'h40; d.ba = 32'h41; d.asz = 1; d.diff = 1;
    send(d, "R2 loads diff writer");
    d.stb = 1; send(d, "R2 store between");
    // R3 AMO feeding a load
    d = blank(); d.ak = 2; d.bfa = 1; d.ba = 32'h800; send(d, "R3 amo fwd");
    // R5 acquire on store ignored, release on load ignored
    d = blank(); d.ak = 1; d.aacq = 1; d.bk = 0; d.brel = 1; d.ba = 32'h20;
    send(d, "R5 misplaced annotations");
    d.ak = 0; d.bk = 3; send(d, "R5 effective annotations");
    // R6 RCsc on both sides
    d.arcsc = 1; d.brcsc = 1; send(d, "R6 rcsc both");
    // R8 control dependency into a load vs a store
    d = blank(); d.dctrl = 1; d.ddata = 1; d.ba = 32'h200; send(d, "R8 ctrl into load");
    d.bk = 1; send(d, "R7 R8 into store");
    // R9 pipeline rules
    d = blank(); d.mst = 1; d.bfm = 1; d.madr = 1; d.ba = 32'h300;
    send(d, "R9 pipe load");
    d.bk = 1; send(d, "R9 pipe store");
    // R4 fence alone
    d = blank(); d.fence = 1; d.ba = 32'h500; send(d, "R4 fence");

    // R12 back-pressure: result holds, input stalls
    d = rand_d(); d2 = rand_d();
    @(negedge clk);
    cur = d; in_valid = 1; out_ready = 0;
    @(negedge clk);
    cur = d2;
    check(in_ready === 1'b0, "R12", "in_ready stalled", longint'(in_ready), 0);
    repeat (3) @(negedge clk);
    check_result(d, "R12 held result");
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check_result(d2, "R12 after release");
    @(negedge clk);
    check(out_valid === 1'b0, "R11", "drained", longint'(out_valid), 0);

    for (int n = 0; n < 3000; n++) begin
      d = rand_d();
      send(d, "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule